// File: doc/BRIEF.md
# Change-Triggered Streaming Input Port

This block is a read-only, memory-mapped port that lets a DMA engine stream samples from an external parallel bus into memory without polling. On every system clock the bus passes through a short register chain. When the newest sample differs from the one before it in any bit, rising or falling, the port captures that sample and raises a data-available flag. The flag doubles as flow control for the DMA engine. The engine is programmed for one long transfer. It reads the data register only while the flag is high and stalls while the flag is low.

Reading the data register returns the captured word and drops the flag, so no acknowledge write is needed. Each input change is therefore delivered exactly once. If the input changes again before the previous word has been read, the newer word replaces the old one and a sticky overrun bit records the loss. Software clears that bit by writing a one to the status address. The external source is expected to change at most once every few system clocks. The port and its reader share one clock.

Top module: `chg_stream_port`

## Requirements
- R1: After reset, data_avail is low, the overrun bit is clear and the captured word is zero, so a data read returns zero.
- R2: A change in any bit of pins_in, in either direction, raises data_avail after exactly SYNC_STAGES+1 rising clock edges (3 edges by default).
- R3: While pins_in is unchanged and no data read is accepted, data_avail keeps its value, and it stays low when there is no new word.
- R4: A read is accepted when cs and rd are high at a rising edge. A read with addr=0 returns the captured word on rdata after that edge and drops data_avail at the same edge.
- R5: rdata returns the captured word and never the live pins. A change still in the sampling chain is not visible to a read.
- R6: If a change is detected at the same edge as an accepted data read, data_avail stays high, the captured word takes the newer sample and overrun is not set. The read returns the older word.
- R7: If a change is detected while data_avail is high and no data read is accepted, the captured word is overwritten and the overrun bit is set.
- R8: A read with addr=1 returns the status word: bit 0 is overrun, bit 1 is data_avail, and the other bits are zero. A write (cs and wr high) to addr=1 with wdata=1 clears overrun. With wdata=0 the write has no effect. A set of overrun at the same edge takes priority over the clear.
- R9: The port is input-only. Writes to addr=0 change neither the captured word nor data_avail, and rdata holds its value when no read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock shared with the reader |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Slave select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 1 | Register select: 0 data, 1 status |
| wdata | input | 1 | Write data bit; 1 clears overrun at the status address |
| rdata | output | DATA_W | Registered read data, one cycle of latency |
| data_avail | output | 1 | High while a captured word is waiting to be read |
| pins_in | input | DATA_W | External parallel input bus |

## Verification
The bound checker watches the flag and the overrun state on every cycle. It checks that a detected change raises the flag and that a lone data read drops it. It checks that the flag holds when nothing happens, that an unread change sets overrun, that the capture register holds the newest sample, and that the clear only acts when no set competes with it. The end-to-end latency from the pins to the flag, the read data itself, and how a read and a change on the same edge interact can only be shown by the bench scenarios. The bench also shows that the live pins never leak onto rdata and that writes to the data address have no effect. These scenarios are checked against a behavioural model that keeps a history of the pin values.

// File: rtl/chg_stream_pkg.sv
// Package: shared register addresses and status bit positions for the
// change-triggered streaming input port.
package chg_stream_pkg;
    localparam logic REG_DATA = 1'b0;   // captured sample word
    localparam logic REG_STAT = 1'b1;   // status word
    localparam int   STAT_OVR_BIT   = 0;
    localparam int   STAT_AVAIL_BIT = 1;
endpackage

// File: rtl/cs_sampler.sv
// cs_sampler: registers the external bus through STAGES flops, keeps the
// previous sampled word and flags any bit difference between the two.
// Assumes the source changes slower than the chain depth; no CDC intended.
module cs_sampler #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] sampled,
    output logic         changed
);
    logic [STAGES-1:0][W-1:0] chain_q;
    logic [W-1:0]             prev_q;

    // Shift the pin value through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pins};
    end

    // Remember the last sampled word for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Flag a change in any bit, in either direction.
    always_comb begin
        sampled = chain_q[STAGES-1];
        changed = |(sampled ^ prev_q);
    end
endmodule

// File: rtl/cs_capture.sv
// cs_capture: holds the captured word, the data-available flag and the
// sticky overrun bit. A new change always wins over a read on the flag,
// and a set of overrun always wins over a clear.
module cs_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         changed,
    input  logic [W-1:0] sampled,
    input  logic         rd_data_acc,
    input  logic         ovr_clr_req,
    output logic [W-1:0] cap_q,
    output logic         avail_q,
    output logic         ovr_q
);
    logic ovr_set;

    // An unread word is lost when a new change lands without a read.
    always_comb ovr_set = changed && avail_q && !rd_data_acc;

    // Load the newest sample whenever a change is detected.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (changed) cap_q <= sampled;
    end

    // Raise on a change, drop on a data read that has no competing change.
    always_ff @(posedge clk) begin
        if (!rst_n)           avail_q <= 1'b0;
        else if (changed)     avail_q <= 1'b1;
        else if (rd_data_acc) avail_q <= 1'b0;
    end

    // Sticky overrun; set takes priority over the write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           ovr_q <= 1'b0;
        else if (ovr_set)     ovr_q <= 1'b1;
        else if (ovr_clr_req) ovr_q <= 1'b0;
    end
endmodule

// File: rtl/cs_regif.sv
// cs_regif: decodes the slave strobes and returns registered read data
// with one cycle of latency. Writes only reach the overrun clear.
module cs_regif
    import chg_stream_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs,
    input  logic         rd,
    input  logic         wr,
    input  logic         addr,
    input  logic         wdata,
    input  logic [W-1:0] cap,
    input  logic         avail,
    input  logic         ovr,
    output logic         rd_data_acc,
    output logic         ovr_clr_req,
    output logic [W-1:0] rdata
);
    logic         rd_acc;
    logic [W-1:0] stat_word;

    // Decode accepted accesses.
    always_comb begin
        rd_acc      = cs && rd;
        rd_data_acc = rd_acc && (addr == REG_DATA);
        ovr_clr_req = cs && wr && (addr == REG_STAT) && wdata;
    end

    // Assemble the status word.
    always_comb begin
        stat_word                 = '0;
        stat_word[STAT_OVR_BIT]   = ovr;
        stat_word[STAT_AVAIL_BIT] = avail;
    end

    // Register the selected word on an accepted read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_acc) rdata <= (addr == REG_DATA) ? cap : stat_word;
    end
endmodule

// File: rtl/chg_stream_port.sv
// chg_stream_port: top of the change-triggered streaming input port.
// Samples the input bus every clock, captures each changed word, and
// exposes it to a DMA reader through a flag that the data read clears.
// Assumes reader and source share clk; DATA_W must be at least 2.
module chg_stream_port #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic              addr,
    input  logic              wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              data_avail,
    input  logic [DATA_W-1:0] pins_in
);
    logic [DATA_W-1:0] sampled;
    logic              changed;
    logic [DATA_W-1:0] cap_q;
    logic              overrun;
    logic              rd_data_acc;
    logic              ovr_clr_req;

    cs_sampler #(.W(DATA_W), .STAGES(SYNC_STAGES)) sampler_i (
        .clk(clk), .rst_n(rst_n), .pins(pins_in),
        .sampled(sampled), .changed(changed)
    );

    cs_capture #(.W(DATA_W)) capture_i (
        .clk(clk), .rst_n(rst_n), .changed(changed), .sampled(sampled),
        .rd_data_acc(rd_data_acc), .ovr_clr_req(ovr_clr_req),
        .cap_q(cap_q), .avail_q(data_avail), .ovr_q(overrun)
    );

    cs_regif #(.W(DATA_W)) regif_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .cap(cap_q), .avail(data_avail),
        .ovr(overrun), .rd_data_acc(rd_data_acc),
        .ovr_clr_req(ovr_clr_req), .rdata(rdata)
    );
endmodule

// File: rtl/chg_stream_chk.sv
// chg_stream_chk: cycle-level properties of the flag, capture register
// and overrun bit, bound into chg_stream_port.
module chg_stream_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              changed,
    input logic [DATA_W-1:0] sampled,
    input logic              rd_data_acc,
    input logic              ovr_clr_req,
    input logic [DATA_W-1:0] cap_q,
    input logic              data_avail,
    input logic              overrun
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!data_avail && !overrun && cap_q == '0));

    a_r2_change_raises: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> data_avail);

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!changed && !rd_data_acc) |=> $stable(data_avail));

    a_r4_read_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_acc && !changed) |=> !data_avail);

    a_r6_newest_kept: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> (cap_q == $past(sampled)));

    a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (changed && data_avail && !rd_data_acc) |=> overrun);

    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr_req && !(changed && data_avail && !rd_data_acc)) |=> !overrun);

    a_r9_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !changed |=> $stable(cap_q));
endmodule

bind chg_stream_port chg_stream_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .changed(changed), .sampled(sampled),
    .rd_data_acc(rd_data_acc), .ovr_clr_req(ovr_clr_req),
    .cap_q(cap_q), .data_avail(data_avail), .overrun(overrun)
);

// File: tb/chg_stream_port_tb_top.sv
// Bench: behavioural reference model (pin history queue) compared on
// every clock, plus directed scenarios per requirement.
module chg_stream_port_tb_top;
    localparam int W  = 16;
    localparam int SS = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0, wdata = 1'b0;
    logic [W-1:0] pins = '0;
    logic [W-1:0] rdata;
    logic         data_avail;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    chg_stream_port #(.DATA_W(W), .SYNC_STAGES(SS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .data_avail(data_avail), .pins_in(pins)
    );

    always #4 clk = ~clk;

    // ---------------- reference model ----------------
    logic [W-1:0] hist[$];
    logic [W-1:0] m_cap, m_rdata;
    bit           m_av, m_ov;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i <= SS; i++) hist.push_back('0);
            m_cap = '0; m_rdata = '0; m_av = 0; m_ov = 0;
        end else begin
            logic [W-1:0] cur, old;
            bit chg, rdd, clr;
            cur = hist[SS-1];
            old = hist[SS];
            chg = (cur != old);
            rdd = cs && rd && !addr;
            clr = cs && wr && addr && wdata;
            if (cs && rd) m_rdata = addr ? {{(W-2){1'b0}}, m_av, m_ov} : m_cap;
            if (chg && m_av && !rdd) m_ov = 1;
            else if (clr)            m_ov = 0;
            if (chg)      m_av = 1;
            else if (rdd) m_av = 0;
            if (chg) m_cap = cur;
            hist.push_front(pins);
            void'(hist.pop_back());
        end
    end

    // Every-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (data_avail !== m_av) begin
                errors++;
                $display("FAIL R2/R3 model data_avail actual=%0b expected=%0b", data_avail, m_av);
            end
            checks++;
            if (rdata !== m_rdata) begin
                errors++;
                $display("FAIL R4 model rdata actual=%h expected=%h", rdata, m_rdata);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_read(input logic a, output logic [W-1:0] v);
        cs = 1; rd = 1; addr = a;
        @(negedge clk);
        cs = 0; rd = 0;
        v = rdata;
    endtask

    task automatic bus_write(input logic a, input logic d);
        cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; wr = 0; wdata = 0;
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic [W-1:0] v;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1
        check("R1 avail after reset", {15'd0, data_avail}, 16'd0);
        bus_read(1'b1, v); check("R1 status after reset", v, 16'h0000);
        bus_read(1'b0, v); check("R1 data after reset", v, 16'h0000);

        // R2 latency and R3 stall
        pins = 16'hA5A5;
        cyc(2); check("R3 no flag inside sampling window", {15'd0, data_avail}, 16'd0);
        cyc(1); check("R2 flag after three edges", {15'd0, data_avail}, 16'd1);
        cyc(4); check("R3 flag holds while idle", {15'd0, data_avail}, 16'd1);

        // R4 read returns word and clears flag
        bus_read(1'b0, v);
        check("R4 data read value", v, 16'hA5A5);
        check("R4 flag cleared", {15'd0, data_avail}, 16'd0);
        cyc(5); check("R3 flag stays low with no change", {15'd0, data_avail}, 16'd0);

        // R2 falling single bit
        pins = 16'hA5A4;
        cyc(3); check("R2 falling bit raises flag", {15'd0, data_avail}, 16'd1);

        // R5 live pins not visible
        pins = 16'h1234;
        bus_read(1'b0, v); check("R5 read returns captured, not pins", v, 16'hA5A4);
        cyc(3);
        check("R5 later change raises flag", {15'd0, data_avail}, 16'd1);
        bus_read(1'b0, v); check("R5 new word after sampling", v, 16'h1234);

        // R7 overrun
        pins = 16'h0F0F; cyc(4);
        pins = 16'hF0F0; cyc(4);
        bus_read(1'b1, v); check("R7 overrun and avail in status", v, 16'h0003);
        bus_read(1'b0, v); check("R7 newest word kept", v, 16'hF0F0);

        // R8 clear semantics
        bus_write(1'b1, 1'b0);
        bus_read(1'b1, v); check("R8 write of zero keeps overrun", v, 16'h0001);
        bus_write(1'b1, 1'b1);
        bus_read(1'b1, v); check("R8 write of one clears overrun", v, 16'h0000);

        // R8 set wins over clear: flag up, then change meets a clear write
        pins = 16'h1111; cyc(4);
        pins = 16'h2222; cyc(2);
        bus_write(1'b1, 1'b1);
        bus_read(1'b1, v); check("R8 set beats clear", v, 16'h0003);
        bus_write(1'b1, 1'b1);
        bus_read(1'b0, v); check("R8 data after set/clear race", v, 16'h2222);

        // R6 change coincides with a data read
        pins = 16'h3333; cyc(4);
        check("R6 setup flag", {15'd0, data_avail}, 16'd1);
        pins = 16'h4444; cyc(2);
        bus_read(1'b0, v);
        check("R6 read returns older word", v, 16'h3333);
        check("R6 flag stays high", {15'd0, data_avail}, 16'd1);
        bus_read(1'b1, v); check("R6 no overrun", v, 16'h0002);
        bus_read(1'b0, v); check("R6 newer word delivered", v, 16'h4444);

        // R9 writes to data address ignored
        bus_write(1'b0, 1'b1);
        cyc(1);
        check("R9 rdata holds without read", rdata, 16'h4444);
        check("R9 write leaves flag low", {15'd0, data_avail}, 16'd0);
        bus_read(1'b0, v); check("R9 captured word unchanged", v, 16'h4444);

        cyc(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule